// File: doc/BRIEF.md
# Signal-Strength Measurement Sequencer

This block controls a signal-strength measurement path in a receiver. One 4-bit flash converter is shared between two analog quantities: the front-end gain-control level and the output of a peak detector placed on the filtered signal. The sequencer works on a fixed frame of two conversion slots. The first slot converts the gain-control level and the second converts the peak level. At the end of every complete slot, the 4-bit result is written into its half of an 8-bit status word.

The block also drives the two switches of the peak detector. The discharge switch empties the hold capacitor. The sample switch connects the detector to the converter.

- **Continuous mode.** The sample switch stays closed and both results track the signal.
- **Sample mode.** The detector is emptied first. The sample switch then closes when an external strobe is seen high. When the strobe falls, the switch opens, the voltage is held, conversions stop and the status word keeps its last results. A later strobe rise starts the whole sequence again.
- **Enable low.** The block goes quiet and its output buffer enable drops.

Top module: `rssi_seq`

## Requirements
- R1: While `rst` is high at a clock edge, `status` is cleared to 0x00.
- R2: While `en` is low, the outputs `sample_sw`, `discharge_sw`, `adc_start` and `buf_en` are all 0, and `status` keeps its value. `buf_en` is 1 whenever `en` is 1.
- R3: The timebase runs whenever `en` is high, in slots of SLOT_LEN (16) cycles, with two slots to a frame. `adc_start` is a one-cycle pulse in the first cycle of a slot in which conversion is active. `adc_chan` is 0 in even slots (gain-control channel) and 1 in odd slots (peak channel).
- R4: The value on `adc_result` in the last cycle of a complete slot is written into `status`, where it is visible from the next cycle. A slot with `adc_chan`=0 writes bits 7:4. A slot with `adc_chan`=1 writes bits 3:0.
- R5: With `en`=1 and `cont_mode`=1, `sample_sw` is 1 and `discharge_sw` is 0 in every cycle, and conversions run in every slot.
- R6: In sample mode (`cont_mode`=0), after `en` rises or `cont_mode` falls, `discharge_sw` is 1 for exactly DISCH_LEN (7) cycles while `sample_sw` is 0. The two switches are never closed together.
- R7: After the discharge phase, `sample_sw` stays 0 and no `adc_start` occurs until `strobe` is sampled high at a clock edge. From the next cycle on, `sample_sw` is 1.
- R8: When `strobe` is sampled low while the sample switch is closed, `sample_sw` is 0 from the next cycle. After that, no `adc_start` occurs and `status` does not change.
- R9: A slot in which conversion is not active for all of its cycles writes nothing. This covers a slot cut short by a strobe fall or by `en` falling.
- R10: In the hold state, a `strobe` sampled high starts a new discharge of DISCH_LEN cycles from the next cycle. `sample_sw` closes one cycle after the discharge ends if `strobe` is still high.
- R11: When `en` rises, the timebase restarts at the first cycle of a gain-control slot (`adc_chan`=0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Block enable; low powers the block down |
| cont_mode | input | 1 | 1 = continuous tracking, 0 = strobe-driven sample mode |
| strobe | input | 1 | Measurement strobe used in sample mode |
| adc_result | input | 4 | Result from the shared flash converter |
| adc_start | output | 1 | Converter start pulse at the beginning of an active slot |
| adc_chan | output | 1 | Converter input select: 0 gain-control level, 1 peak level |
| discharge_sw | output | 1 | Closes the peak-detector discharge switch |
| sample_sw | output | 1 | Closes the sample-and-hold switch |
| buf_en | output | 1 | Enable for the analog output buffer |
| status | output | 8 | Results: gain-control level in bits 7:4, peak level in bits 3:0 |

## Verification
The hardest case to reach from the ports is a conversion slot that has begun but is cut short. Its partial result must leave no trace in `status`, and the same slot timing must carry over into the next strobe sequence.

The stimulus reaches this case in three places:
- It drops `en` four cycles into a peak slot during continuous operation.
- It lets the strobe fall partway through a peak slot in sample mode.
- It closes the sample switch in the middle of a slot, so the first slot is only partly covered.

In each case, `adc_result` carries a value that differs from the nibble it would overwrite. The scoreboard therefore reports any stray write as an unexpected change. The bench also raises the strobe again from the hold state and checks the repeated discharge cycle by cycle.

// File: rtl/rssi_pkg.sv
package rssi_pkg;

    localparam int RES_W  = 4;
    localparam int STAT_W = 2 * RES_W;

    typedef enum logic [1:0] {
        PH_DISCH,
        PH_ARMED,
        PH_TRACK,
        PH_HOLD
    } phase_e;

    typedef struct packed {
        logic [RES_W-1:0] gain;
        logic [RES_W-1:0] peak;
    } rssi_stat_t;

    // Write one converter result into the nibble chosen by the channel.
    function automatic rssi_stat_t put_nibble(rssi_stat_t s, logic ch,
                                              logic [RES_W-1:0] v);
        rssi_stat_t r;
        r = s;
        if (ch) r.peak = v;
        else    r.gain = v;
        return r;
    endfunction

endpackage

// File: rtl/rssi_timebase.sv
module rssi_timebase #(
    parameter int SLOT_LEN = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic slot_first,
    output logic slot_last,
    output logic chan
);
    localparam int PW = (SLOT_LEN > 2) ? $clog2(SLOT_LEN) : 1;
    localparam logic [PW-1:0] LAST = PW'(SLOT_LEN - 1);

    logic [PW-1:0] pos;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            pos  <= '0;
            chan <= 1'b0;
        end else if (pos == LAST) begin
            pos  <= '0;
            chan <= ~chan;
        end else begin
            pos  <= pos + 1'b1;
        end
    end

    assign slot_first = (pos == '0);
    assign slot_last  = (pos == LAST);

endmodule

// File: rtl/rssi_phase_fsm.sv
module rssi_phase_fsm
    import rssi_pkg::*;
#(
    parameter int DISCH_LEN = 7
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic cont_mode,
    input  logic strobe,
    output logic discharge_sw,
    output logic sample_sw
);
    localparam int DW = (DISCH_LEN > 1) ? $clog2(DISCH_LEN + 1) : 1;
    localparam logic [DW-1:0] DLAST = DW'(DISCH_LEN - 1);

    phase_e        phase;
    logic [DW-1:0] dcnt;

    always_ff @(posedge clk) begin
        if (rst || !en || cont_mode) begin
            phase <= PH_DISCH;
            dcnt  <= '0;
        end else begin
            unique case (phase)
                PH_DISCH: begin
                    if (dcnt == DLAST) begin
                        phase <= PH_ARMED;
                        dcnt  <= '0;
                    end else begin
                        dcnt <= dcnt + 1'b1;
                    end
                end
                PH_ARMED: if (strobe)  phase <= PH_TRACK;
                PH_TRACK: if (!strobe) phase <= PH_HOLD;
                PH_HOLD: begin
                    // Entered with strobe low, so a high sample here is a new rise.
                    if (strobe) begin
                        phase <= PH_DISCH;
                        dcnt  <= '0;
                    end
                end
                default: phase <= PH_DISCH;
            endcase
        end
    end

    assign discharge_sw = en && !cont_mode && (phase == PH_DISCH);
    assign sample_sw    = en && (cont_mode || (phase == PH_TRACK));

endmodule

// File: rtl/rssi_capture.sv
module rssi_capture
    import rssi_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             active,
    input  logic             slot_first,
    input  logic             slot_last,
    input  logic             chan,
    input  logic [RES_W-1:0] result,
    output rssi_stat_t       stat
);
    // Set while every cycle of the current slot so far has been active.
    logic slot_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            stat    <= '0;
            slot_ok <= 1'b0;
        end else begin
            if (slot_first) slot_ok <= active;
            else            slot_ok <= slot_ok && active;
            if (slot_last && slot_ok && active)
                stat <= put_nibble(stat, chan, result);
        end
    end

endmodule

// File: rtl/rssi_seq.sv
module rssi_seq
    import rssi_pkg::*;
#(
    parameter int SLOT_LEN  = 16,
    parameter int DISCH_LEN = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              cont_mode,
    input  logic              strobe,
    input  logic [RES_W-1:0]  adc_result,
    output logic              adc_start,
    output logic              adc_chan,
    output logic              discharge_sw,
    output logic              sample_sw,
    output logic              buf_en,
    output logic [STAT_W-1:0] status
);
    logic       slot_first;
    logic       slot_last;
    logic       chan;
    rssi_stat_t stat;

    rssi_timebase #(.SLOT_LEN(SLOT_LEN)) i_timebase (
        .clk        (clk),
        .rst        (rst),
        .en         (en),
        .slot_first (slot_first),
        .slot_last  (slot_last),
        .chan       (chan)
    );

    rssi_phase_fsm #(.DISCH_LEN(DISCH_LEN)) i_phase (
        .clk          (clk),
        .rst          (rst),
        .en           (en),
        .cont_mode    (cont_mode),
        .strobe       (strobe),
        .discharge_sw (discharge_sw),
        .sample_sw    (sample_sw)
    );

    // Conversion runs exactly while the sample switch is closed.
    rssi_capture i_capture (
        .clk        (clk),
        .rst        (rst),
        .active     (sample_sw),
        .slot_first (slot_first),
        .slot_last  (slot_last),
        .chan       (chan),
        .result     (adc_result),
        .stat       (stat)
    );

    assign adc_start = sample_sw && slot_first;
    assign adc_chan  = chan;
    assign buf_en    = en;
    assign status    = stat;

endmodule

// File: rtl/rssi_seq_chk.sv
module rssi_seq_chk #(
    parameter int DISCH_LEN = 7
) (
    input logic       clk,
    input logic       rst,
    input logic       en,
    input logic       cont_mode,
    input logic       adc_start,
    input logic       discharge_sw,
    input logic       sample_sw,
    input logic       buf_en,
    input logic [7:0] status
);
    logic [7:0] dis_run;

    always_ff @(posedge clk) begin
        if (rst)               dis_run <= '0;
        else if (!discharge_sw) dis_run <= '0;
        else if (dis_run != 8'hFF) dis_run <= dis_run + 1'b1;
    end

    assert_off_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        !en |-> (!sample_sw && !discharge_sw && !adc_start && !buf_en));

    assert_off_status_R2: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(status));

    assert_start_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        adc_start |=> !adc_start);

    assert_cont_switches_R5: assert property (@(posedge clk) disable iff (rst)
        (en && cont_mode) |-> (sample_sw && !discharge_sw));

    assert_switch_excl_R6: assert property (@(posedge clk) disable iff (rst)
        !(sample_sw && discharge_sw));

    assert_disch_len_R6: assert property (@(posedge clk) disable iff (rst)
        ($fell(discharge_sw) && en && !cont_mode) |-> (dis_run == 8'(DISCH_LEN)));

    assert_hold_frozen_R8: assert property (@(posedge clk) disable iff (rst)
        (en && !cont_mode && !sample_sw) |=> $stable(status));

endmodule

bind rssi_seq rssi_seq_chk #(.DISCH_LEN(DISCH_LEN)) i_chk (.*);

// File: tb/test_rssi_seq.sv
module test_rssi_seq;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b0;
    logic       cont_mode = 1'b0;
    logic       strobe = 1'b0;
    logic [3:0] adc_result = 4'h0;
    logic       adc_start, adc_chan, discharge_sw, sample_sw, buf_en;
    logic [7:0] status;

    int checks = 0;
    int failures = 0;
    logic [7:0] exp_q[$];
    logic [7:0] exp_stat = 8'h00;
    logic [7:0] prev_stat = 8'h00;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rssi_seq i_rssi_seq (
        .clk(clk), .rst(rst), .en(en), .cont_mode(cont_mode), .strobe(strobe),
        .adc_result(adc_result), .adc_start(adc_start), .adc_chan(adc_chan),
        .discharge_sw(discharge_sw), .sample_sw(sample_sw), .buf_en(buf_en),
        .status(status)
    );

    task automatic check(input bit ok, input string req,
                         input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Driver side: record the status value a complete slot will produce.
    task automatic push_slot(input logic ch, input logic [3:0] v);
        if (ch) exp_stat[3:0] = v;
        else    exp_stat[7:4] = v;
        exp_q.push_back(exp_stat);
    endtask

    // Monitor: every change of status must match the next expected item.
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (status !== prev_stat) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R9 unexpected status write", status, prev_stat);
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    check(status === e, "R4 status update", status, e);
                end
            end
            prev_stat <= status;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [3:0] cvals [5];
        cvals[0] = 4'hA; cvals[1] = 4'h5; cvals[2] = 4'h3;
        cvals[3] = 4'hC; cvals[4] = 4'h7;

        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check(status === 8'h00, "R1 reset status", status, 8'h00);
        check({sample_sw, discharge_sw, adc_start, buf_en} === 4'b0000,
              "R2 outputs off", {4'h0, sample_sw, discharge_sw, adc_start, buf_en}, 8'h00);

        // Continuous mode: five full slots, then en drops 4 cycles into slot 5.
        @(posedge clk); #1;
        cont_mode = 1'b1;
        en = 1'b1;
        for (int i = 0; i < 85; i++) begin
            int k;
            k = i / 16;
            adc_result = (k < 5) ? cvals[k] : 4'hF;
            if (i % 16 == 0 && k < 5) push_slot(k[0], cvals[k]);
            @(negedge clk);
            check(sample_sw === 1'b1 && discharge_sw === 1'b0, "R5 cont switches",
                  {6'h0, sample_sw, discharge_sw}, 8'h02);
            check(adc_start === (i % 16 == 0), "R3 start pulse",
                  {7'h0, adc_start}, {7'h0, (i % 16 == 0)});
            if (i % 16 == 0)
                check(adc_chan === k[0], "R3 channel order", {7'h0, adc_chan}, {7'h0, k[0]});
            if (i == 0)
                check(buf_en === 1'b1, "R2 buffer enable", {7'h0, buf_en}, 8'h01);
            @(posedge clk); #1;
        end

        // Disabled: partial peak slot discarded, outputs quiet.
        en = 1'b0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            check({sample_sw, discharge_sw, adc_start, buf_en} === 4'b0000,
                  "R2 off outputs", {4'h0, sample_sw, discharge_sw, adc_start, buf_en}, 8'h00);
            @(posedge clk); #1;
        end
        check(status === 8'h7C, "R9 disable discards slot", status, 8'h7C);

        // Sample mode sequence.
        cont_mode = 1'b0;
        en = 1'b1;
        for (int j = 0; j < 106; j++) begin
            bit exp_start;
            strobe = ((j >= 10 && j < 52) || (j >= 85 && j < 97));
            if (j >= 16 && j < 32)      adc_result = 4'h9;
            else if (j >= 32 && j < 48) adc_result = 4'h2;
            else if (j >= 48 && j < 64) adc_result = 4'h0;
            else                        adc_result = 4'hF;
            if (j == 16) push_slot(1'b1, 4'h9);
            if (j == 32) push_slot(1'b0, 4'h2);
            @(negedge clk);
            if (j == 0)
                check(adc_chan === 1'b0, "R11 restart on gain channel", {7'h0, adc_chan}, 8'h00);
            if (j <= 6)
                check(discharge_sw === 1'b1 && sample_sw === 1'b0, "R6 discharge phase",
                      {6'h0, discharge_sw, sample_sw}, 8'h02);
            if (j >= 7 && j <= 10)
                check(discharge_sw === 1'b0 && sample_sw === 1'b0, "R7 armed waits",
                      {6'h0, discharge_sw, sample_sw}, 8'h00);
            if (j == 11)
                check(sample_sw === 1'b1, "R7 sample closes", {7'h0, sample_sw}, 8'h01);
            if (j == 16 || j == 32)
                check(adc_chan === (j == 16), "R3 slot channel", {7'h0, adc_chan},
                      {7'h0, (j == 16)});
            exp_start = (j == 16 || j == 32 || j == 48);
            if (j < 85)
                check(adc_start === exp_start, "R8 start only while tracking",
                      {7'h0, adc_start}, {7'h0, exp_start});
            if (j >= 53 && j < 86)
                check(sample_sw === 1'b0, "R8 hold opens switch", {7'h0, sample_sw}, 8'h00);
            if (j == 80)
                check(status === 8'h29, "R8 frozen status", status, 8'h29);
            if (j >= 86 && j <= 92)
                check(discharge_sw === 1'b1 && sample_sw === 1'b0, "R10 repeat discharge",
                      {6'h0, discharge_sw, sample_sw}, 8'h02);
            if (j == 93)
                check(discharge_sw === 1'b0 && sample_sw === 1'b0, "R10 discharge ends",
                      {6'h0, discharge_sw, sample_sw}, 8'h00);
            if (j == 94)
                check(sample_sw === 1'b1, "R10 sample recloses", {7'h0, sample_sw}, 8'h01);
            @(posedge clk); #1;
        end
        @(negedge clk);
        check(status === 8'h29, "R9 partial slots discarded", status, 8'h29);
        check(exp_q.size() == 0, "R4 all expected writes seen", 8'(exp_q.size()), 8'h00);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule